// File: doc/BRIEF.md
# Bit-Addressed Keyboard and Cassette Port

This block decodes a bit-addressed serial I/O space for a small console. It serves a matrix keyboard, a cassette interface, a video-enable line and an optional ROM bank switch. The CPU writes one bit at a time. Bit 0 of the address is ignored, bits 3:1 pick one of eight slots, and bits 15:11 pick a region. The keyboard region is 5'b11100 (0xE000 to 0xE7FE) and the cassette region is 5'b11101 (0xE800 to 0xEFFE). Address bits 10:4 are not decoded, so each region is mirrored.

Byte reads return one captured value in `rd_data`. In the keyboard region this is the active-low column byte of the currently selected row. In the cassette region it is the tape comparator level in bit 7. The key matrix arrives flattened on `key_matrix`, with row r in bits [r*8 +: 8]. Only rows below `KEY_ROWS` carry keys; any other row reads as all ones.

Top module: `kbd_tape_port`

## Requirements
- R1: After reset, `row_sel` is 0, `bank_sel` is 0, `video_en` is 0, `tape_out` is 0 and `rd_data` is 8'h00.
- R2: A write of bit 0 to keyboard slot k, for k in 0..5, sets `row_sel` to k from the next clock edge. A write of bit 1 to those slots leaves `row_sel` unchanged.
- R3: With `BANKED`=1, a write to keyboard slot 0 sets `bank_sel` to the written bit, in addition to the row behaviour of R2. No other write changes `bank_sel`.
- R4: A write to keyboard slot 7 (0xE00E) sets `video_en` to the written bit.
- R5: A write to keyboard slot 6 (0xE00C) changes no output.
- R6: A write to cassette slot 7 (0xE80E) sets `tape_out` to the written bit. A value of 1 means positive level and 0 means negative level.
- R7: A read strobe in the keyboard region loads `rd_data` with the column byte of the selected row. In that byte, 0 means a key is pressed.
- R8: A read strobe in the cassette region loads `rd_data` with `tape_in` in bit 7 and zeros in bits 6:0.
- R9: Address bits 10:4 and bit 0 are ignored, for writes and for reads.
- R10: Writes outside both regions, and writes to cassette slots 0..6, change no output. Reads outside both regions return 8'h00.
- R11: `rd_data` changes only at the clock edge that samples `rd_stb` high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | Bit address of the access |
| wr_bit | input | 1 | Bit value being written |
| wr_stb | input | 1 | Write strobe, one cycle |
| rd_stb | input | 1 | Read strobe, one cycle |
| key_matrix | input | 64 | Column lines of all rows, row r in [r*8 +: 8], active low |
| tape_in | input | 1 | Cassette comparator, 1 when the tape level is positive |
| rd_data | output | 8 | Byte captured by the last read strobe |
| row_sel | output | 3 | Selected keyboard row |
| bank_sel | output | 1 | ROM bank select |
| video_en | output | 1 | Video enable |
| tape_out | output | 1 | Cassette output level |

## Verification
The bench writes bit 1 to a row slot. A design that selected the row on any write would move `row_sel` there. It also aims at slot 0, which updates the bank and the row together. A decoder that treated these as exclusive would drop one of the two updates. Mirrored addresses, slot 6, the unused cassette slots and an address outside both regions are all driven. A decoder that looked at too few or too many address bits would change an output or return the wrong byte. Finally, the bench changes `tape_in` without a strobe, which catches a read path that is transparent instead of captured.

// File: rtl/kbtp_pkg.sv
package kbtp_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_KEYS = 2'd1,
    RGN_TAPE = 2'd2
  } region_t;

  localparam logic [4:0] KEYS_TAG = 5'b11100;
  localparam logic [4:0] TAPE_TAG = 5'b11101;
  localparam logic [2:0] SLOT_VIDEO = 3'd7;
  localparam logic [2:0] SLOT_TAPE = 3'd7;
  localparam logic [2:0] SLOT_BANK = 3'd0;

  // Region from the top five address bits; bits 10:4 are a mirror.
  function automatic region_t region_of(input logic [4:0] top_bits);
    case (top_bits)
      KEYS_TAG: region_of = RGN_KEYS;
      TAPE_TAG: region_of = RGN_TAPE;
      default:  region_of = RGN_NONE;
    endcase
  endfunction

  // Slot index within a region; the lowest address bit is dropped.
  function automatic logic [2:0] slot_of(input logic [2:0] mid_bits);
    slot_of = mid_bits;
  endfunction
endpackage

// File: rtl/kbtp_wr_decode.sv
module kbtp_wr_decode
  import kbtp_pkg::*;
#(
  parameter int KEY_ROWS = 6,
  parameter int ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      io_addr,
  input  logic             wr_stb,
  input  logic             wr_bit,
  output region_t          region,
  output logic             row_ev,
  output logic [ROW_W-1:0] row_idx,
  output logic             bank_ev,
  output logic             vid_ev,
  output logic             tape_ev
);
  logic [2:0] slot;
  logic       in_keys;
  logic       in_tape;
  logic       addr_unused;

  assign addr_unused = ^{io_addr[10:4], io_addr[0]};
  assign region  = region_of(io_addr[15:11]);
  assign slot    = slot_of(io_addr[3:1]);
  assign in_keys = (region == RGN_KEYS);
  assign in_tape = (region == RGN_TAPE);

  assign row_idx = ROW_W'(slot);
  assign row_ev  = wr_stb && in_keys && !wr_bit && (int'(slot) < KEY_ROWS);
  assign bank_ev = wr_stb && in_keys && (slot == SLOT_BANK);
  assign vid_ev  = wr_stb && in_keys && (slot == SLOT_VIDEO);
  assign tape_ev = wr_stb && in_tape && (slot == SLOT_TAPE);

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_ev, vid_ev, tape_ev})); // R5
  AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> !(row_ev || bank_ev || vid_ev || tape_ev)); // R10
endmodule

// File: rtl/kbtp_ctrl_regs.sv
module kbtp_ctrl_regs #(
  parameter int ROW_W = 3,
  parameter int KEY_ROWS = 6,
  parameter bit BANKED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_bit,
  input  logic             row_ev,
  input  logic [ROW_W-1:0] row_idx,
  input  logic             bank_ev,
  input  logic             vid_ev,
  input  logic             tape_ev,
  output logic [ROW_W-1:0] row_sel,
  output logic             bank_sel,
  output logic             video_en,
  output logic             tape_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_sel  <= '0;
      video_en <= 1'b0;
      tape_out <= 1'b0;
    end else begin
      if (row_ev)  row_sel  <= row_idx;
      if (vid_ev)  video_en <= wr_bit;
      if (tape_ev) tape_out <= wr_bit;
    end
  end

  generate
    if (BANKED) begin : g_bank
      logic bank_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bank_q <= 1'b0;
        else if (bank_ev) bank_q <= wr_bit;
      end
      assign bank_sel = bank_q;

      AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bank_ev |=> bank_sel == $past(wr_bit)); // R3
      AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_ev |=> $stable(bank_sel)); // R3
    end else begin : g_nobank
      logic bank_unused;
      assign bank_unused = bank_ev;
      assign bank_sel = 1'b0;
    end
  endgenerate

  AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    row_ev |=> row_sel == $past(row_idx)); // R2
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !row_ev |=> $stable(row_sel)); // R5
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_sel) < KEY_ROWS); // R2
  AST_VID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    vid_ev |=> video_en == $past(wr_bit)); // R4
  AST_TAPE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tape_ev |=> tape_out == $past(wr_bit)); // R6
  AST_TAPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tape_ev |=> $stable(tape_out)); // R10
endmodule

// File: rtl/kbtp_rd_mux.sv
module kbtp_rd_mux
  import kbtp_pkg::*;
#(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  parameter int KEY_ROWS = 6,
  parameter int ROW_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_stb,
  input  region_t              region,
  input  logic [ROW_W-1:0]     row_sel,
  input  logic [ROWS*COLS-1:0] key_matrix,
  input  logic                 tape_in,
  output logic [COLS-1:0]      rd_data
);
  logic [COLS-1:0] keys_byte;
  logic [COLS-1:0] rd_next;

  // Rows without keys float high: all columns read released.
  always_comb begin
    keys_byte = '1;
    for (int r = 0; r < KEY_ROWS; r++) begin
      if (int'(row_sel) == r) keys_byte = key_matrix[r*COLS +: COLS];
    end
  end

  always_comb begin
    case (region)
      RGN_KEYS: rd_next = keys_byte;
      RGN_TAPE: rd_next = {tape_in, {(COLS-1){1'b0}}};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= rd_next;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data)); // R11
  AST_RD_TAPE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && region == RGN_TAPE) |=> rd_data[COLS-2:0] == '0); // R8
  AST_RD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && region == RGN_NONE) |=> rd_data == '0); // R10
endmodule

// File: rtl/kbd_tape_port.sv
module kbd_tape_port
  import kbtp_pkg::*;
#(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  parameter int KEY_ROWS = 6,
  parameter bit BANKED = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [15:0]                 io_addr,
  input  logic                        wr_bit,
  input  logic                        wr_stb,
  input  logic                        rd_stb,
  input  logic [ROWS*COLS-1:0]        key_matrix,
  input  logic                        tape_in,
  output logic [COLS-1:0]             rd_data,
  output logic [$clog2(ROWS)-1:0]     row_sel,
  output logic                        bank_sel,
  output logic                        video_en,
  output logic                        tape_out
);
  localparam int ROW_W = $clog2(ROWS);

  region_t          region;
  logic             row_ev;
  logic [ROW_W-1:0] row_idx;
  logic             bank_ev;
  logic             vid_ev;
  logic             tape_ev;

  kbtp_wr_decode #(.KEY_ROWS(KEY_ROWS), .ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .wr_stb(wr_stb),
    .wr_bit(wr_bit), .region(region), .row_ev(row_ev), .row_idx(row_idx),
    .bank_ev(bank_ev), .vid_ev(vid_ev), .tape_ev(tape_ev)
  );

  kbtp_ctrl_regs #(.ROW_W(ROW_W), .KEY_ROWS(KEY_ROWS), .BANKED(BANKED)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_bit(wr_bit), .row_ev(row_ev),
    .row_idx(row_idx), .bank_ev(bank_ev), .vid_ev(vid_ev), .tape_ev(tape_ev),
    .row_sel(row_sel), .bank_sel(bank_sel), .video_en(video_en),
    .tape_out(tape_out)
  );

  kbtp_rd_mux #(.COLS(COLS), .ROWS(ROWS), .KEY_ROWS(KEY_ROWS), .ROW_W(ROW_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .region(region),
    .row_sel(row_sel), .key_matrix(key_matrix), .tape_in(tape_in),
    .rd_data(rd_data)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (row_sel == '0 && !video_en && !tape_out && !bank_sel)); // R1
endmodule

// File: tb/kbd_tape_port_bench.sv
module kbd_tape_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        wr_bit = 1'b0;
  logic        wr_stb = 1'b0;
  logic        rd_stb = 1'b0;
  logic [63:0] key_matrix;
  logic        tape_in = 1'b0;
  logic [7:0]  rd_data;
  logic [2:0]  row_sel;
  logic        bank_sel;
  logic        video_en;
  logic        tape_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  kbd_tape_port u_kbd_tape_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .wr_bit(wr_bit),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .key_matrix(key_matrix),
    .tape_in(tape_in), .rd_data(rd_data), .row_sel(row_sel),
    .bank_sel(bank_sel), .video_en(video_en), .tape_out(tape_out)
  );

  function automatic logic [7:0] key_pat(input int r);
    key_pat = 8'hA5 ^ 8'(r * 29);
  endfunction

  // {op(2): 0 write 1 read, addr(16), bit, exp row(3), exp video, exp tape, exp rd(8)}
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 16'hE004, 1'b0, 3'd2, 1'b0, 1'b0, 8'h00}, // R2 select row 2
    {2'd1, 16'hE000, 1'b0, 3'd2, 1'b0, 1'b0, 8'h9F}, // R7 row 2 columns
    {2'd0, 16'hE006, 1'b1, 3'd2, 1'b0, 1'b0, 8'h00}, // R2 bit 1 ignored
    {2'd0, 16'hE00A, 1'b0, 3'd5, 1'b0, 1'b0, 8'h00}, // R2 row 5
    {2'd1, 16'hE7F0, 1'b0, 3'd5, 1'b0, 1'b0, 8'h34}, // R9 mirrored read
    {2'd0, 16'hE00E, 1'b1, 3'd5, 1'b1, 1'b0, 8'h00}, // R4 video on
    {2'd0, 16'hE00C, 1'b0, 3'd5, 1'b1, 1'b0, 8'h00}, // R5 slot 6 inert
    {2'd0, 16'hE80E, 1'b1, 3'd5, 1'b1, 1'b1, 8'h00}, // R6 tape positive
    {2'd1, 16'hE800, 1'b0, 3'd5, 1'b1, 1'b1, 8'h80}, // R8 tape level
    {2'd0, 16'hE808, 1'b0, 3'd5, 1'b1, 1'b1, 8'h00}, // R10 cassette slot 4 inert
    {2'd0, 16'hE7F2, 1'b0, 3'd1, 1'b1, 1'b1, 8'h00}, // R9 mirrored row write
    {2'd1, 16'hE000, 1'b0, 3'd1, 1'b1, 1'b1, 8'hB8}, // R7 row 1 columns
    {2'd0, 16'hA002, 1'b0, 3'd1, 1'b1, 1'b1, 8'h00}, // R10 outside write
    {2'd1, 16'h1234, 1'b0, 3'd1, 1'b1, 1'b1, 8'h00}, // R10 outside read
    {2'd0, 16'hE00E, 1'b0, 3'd1, 1'b0, 1'b1, 8'h00}, // R4 video off
    {2'd0, 16'hE80E, 1'b0, 3'd1, 1'b0, 1'b0, 8'h00}, // R6 tape negative
    {2'd0, 16'hE008, 1'b0, 3'd4, 1'b0, 1'b0, 8'h00}, // R2 row 4
    {2'd1, 16'hE00F, 1'b0, 3'd4, 1'b0, 1'b0, 8'hD1}  // R9 bit 0 ignored
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic b);
    @(negedge clk);
    io_addr = a; wr_bit = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 8; r++) key_matrix[r*8 +: 8] = key_pat(r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 row", 8'(row_sel), 8'h00);
    check("R1 bank", 8'(bank_sel), 8'h00);
    check("R1 video", 8'(video_en), 8'h00);
    check("R1 tape", 8'(tape_out), 8'h00);
    check("R1 rd_data", rd_data, 8'h00);

    tape_in = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      if (v[31:30] == 2'd0) do_write(v[29:14], v[13]);
      else do_read(v[29:14]);
      check("R2 row", 8'(row_sel), 8'(v[12:10]));
      check("R4 video", 8'(video_en), 8'(v[9]));
      check("R6 tape", 8'(tape_out), 8'(v[8]));
      check("R3 bank untouched", 8'(bank_sel), 8'h00);
      if (v[31:30] == 2'd1) check("R7/R8 read", rd_data, v[7:0]);
    end

    // R3: slot 0 updates bank and row logic together
    do_write(16'hE000, 1'b1);
    check("R3 bank set", 8'(bank_sel), 8'h01);
    check("R3 row kept on bit 1", 8'(row_sel), 8'h04);
    do_write(16'hE7F0, 1'b0);
    check("R3 bank clear mirror", 8'(bank_sel), 8'h00);
    check("R2 row 0 via slot 0", 8'(row_sel), 8'h00);
    do_read(16'hE000);
    check("R7 row 0 columns", rd_data, 8'hA5);

    // R8 with low tape, then R11 hold without strobe
    tape_in = 1'b0;
    do_read(16'hE80A);
    check("R8 tape low", rd_data, 8'h00);
    tape_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 hold without strobe", rd_data, 8'h00);
    do_read(16'hE800);
    check("R11 capture on strobe", rd_data, 8'h80);

    // R1 mid-run reset
    do_write(16'hE000, 1'b1);
    do_write(16'hE00E, 1'b1);
    do_write(16'hE80E, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 row after reset", 8'(row_sel), 8'h00);
    check("R1 bank after reset", 8'(bank_sel), 8'h00);
    check("R1 video after reset", 8'(video_en), 8'h00);
    check("R1 tape after reset", 8'(tape_out), 8'h00);
    check("R1 rd_data after reset", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule